// File: doc/BRIEF.md
# Chipset configuration and shadow-RAM controller

This block is the I/O-mapped configuration unit of a legacy PC chipset. Software writes a register number to an index port and then reads or writes the selected 8-bit register through a neighbouring data port. Most of the bank is plain storage. Six registers set, for each 16 KB segment of the upper memory area (0xA0000 to 0xFFFFF), whether a memory read is served by internal DRAM or by the external bus, and the same choice for a write.

The routing outputs follow the memory address input combinationally, so the memory controller can steer each access in the cycle it is presented. Two summary flags say whether any segment in the top 128 KB (the BIOS area) reads or writes internal RAM. Two further ports have side effects only. A write to one of them drops the A20 gate and a read raises it. A read of the other emits a one-cycle CPU soft-reset pulse.

Top module: `cfgshd_top`

## Requirements
- R1: A write to port 0xEC loads the index register. A read of port 0xEC returns the index that is currently held. The index resets to 0x00.
- R2: A read of port 0xED returns the register chosen by the index. After reset, 0x00 reads 0x90, 0x01 reads 0xFF, 0x02 reads 0x8A, 0x03 reads 0x88, 0x06 reads 0x1B and 0x08 reads 0x38. Every other index reads 0x00, including any index above 0x24.
- R3: A data-port write changes the selected register only when the index lies in 0x01..0x24. With any other index (0x00 included) the write leaves every register unchanged.
- R4: A write to register 0x05 updates bits 7..5 and 3..0 from the data. Bit 4 keeps its previous value.
- R5: The 2-bit segment code is decoded as follows. Bit 1 set means reads use internal RAM; clear means reads go to the external bus. Bit 0 set means writes use internal RAM; clear means writes go to the external bus.
- R6: Registers 0x0D..0x12 cover the 64 KB regions at 0xA0000, 0xB0000, 0xC0000, 0xD0000, 0xE0000 and 0xF0000 in that order. Within a register, bits [1:0] hold the code of the lowest 16 KB segment and bits [7:6] hold the code of the highest.
- R7: For any memory address below 0xA0000, both rd_internal and wr_internal are 1.
- R8: bios_shd_rd is 1 exactly when some segment at or above 0xE0000 has code bit 1 set. bios_shd_wr is 1 exactly when some such segment has code bit 0 set.
- R9: a20_gate resets to 0. It becomes 0 on the clock edge that accepts a write to port 0xEE, and 1 on the edge that accepts a read of port 0xEE. Otherwise it holds its value.
- R10: A read of port 0xEF raises soft_reset for exactly the one cycle that follows the accepting edge.
- R11: A read of port 0xEE, of port 0xEF, or of any port other than 0xEC and 0xED returns 0xFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| io_addr | input | 16 | I/O port address |
| io_wdata | input | 8 | I/O write data |
| io_wr | input | 1 | I/O write strobe, one cycle per access |
| io_rd | input | 1 | I/O read strobe, one cycle per access |
| io_rdata | output | 8 | Read data for io_addr (combinational) |
| mem_addr | input | 20 | Memory access address |
| rd_internal | output | 1 | 1: a read at mem_addr uses internal RAM; 0: external bus |
| wr_internal | output | 1 | 1: a write at mem_addr uses internal RAM; 0: external bus |
| bios_shd_rd | output | 1 | Some BIOS-area segment reads internal RAM |
| bios_shd_wr | output | 1 | Some BIOS-area segment writes internal RAM |
| a20_gate | output | 1 | A20 gate enable |
| soft_reset | output | 1 | One-cycle CPU soft-reset pulse |

## Verification
The properties assume that io_rd and io_wr are never high in the same cycle, and that each strobe stays high for one cycle per access. The port side effects and the A20 hold rule are defined only under that assumption. The bench drives all I/O through one write task and one read task. Each task raises a single strobe for exactly one clock, between negative edges. The randomized index/data writes and the memory addresses are drawn from ranges that stay clear of ports 0xEE and 0xEF, so the A20 and reset checks remain directed.

// File: rtl/cfgshd_pkg.sv
package cfgshd_pkg;

    localparam int BYTE_W = 8;

    typedef logic [BYTE_W-1:0] cfg_byte_t;

    // 2-bit segment routing code: upper bit = read internal, lower = write internal
    typedef struct packed {
        logic rd_int;
        logic wr_int;
    } seg_route_t;

    // which side port an I/O address hits
    typedef enum logic [2:0] {
        PSEL_NONE,
        PSEL_INDEX,
        PSEL_DATA,
        PSEL_A20,
        PSEL_RESET
    } port_sel_t;

    function automatic cfg_byte_t reset_value(input int idx);
        case (idx)
            0:       return 8'h90;
            1:       return 8'hFF;
            2:       return 8'h8A;
            3:       return 8'h88;
            6:       return 8'h1B;
            8:       return 8'h38;
            default: return 8'h00;
        endcase
    endfunction

    function automatic seg_route_t decode_code(input logic [1:0] code);
        seg_route_t r;
        r.rd_int = code[1];
        r.wr_int = code[0];
        return r;
    endfunction

    function automatic port_sel_t port_decode(input logic [15:0] addr,
                                              input logic [15:0] base);
        if (addr == base)                return PSEL_INDEX;
        if (addr == base + 16'd1)        return PSEL_DATA;
        if (addr == base + 16'd2)        return PSEL_A20;
        if (addr == base + 16'd3)        return PSEL_RESET;
        return PSEL_NONE;
    endfunction

endpackage

// File: rtl/cfgshd_regbank.sv
module cfgshd_regbank
    import cfgshd_pkg::*;
#(
    parameter int        NUM_REGS  = 37,
    parameter int        WIN_LO    = 1,
    parameter int        WIN_HI    = 36,
    parameter int        LOCK_IDX  = 5,
    parameter cfg_byte_t LOCK_MASK = 8'h10
) (
    input  logic                             clk,
    input  logic                             rst,
    input  logic                             idx_we,
    input  logic                             data_we,
    input  cfg_byte_t                        wdata,
    output cfg_byte_t                        index_o,
    output cfg_byte_t                        data_o,
    output logic [NUM_REGS-1:0][BYTE_W-1:0]  regs_o
);

    cfg_byte_t index_q;

    always_ff @(posedge clk) begin
        if (rst)         index_q <= '0;
        else if (idx_we) index_q <= wdata;
    end

    for (genvar gi = 0; gi < NUM_REGS; gi++) begin : g_reg
        localparam cfg_byte_t KEEP  = (gi == LOCK_IDX) ? LOCK_MASK : 8'h00;
        localparam cfg_byte_t RSTV  = reset_value(gi);
        if ((gi >= WIN_LO) && (gi <= WIN_HI)) begin : g_rw
            always_ff @(posedge clk) begin
                if (rst)
                    regs_o[gi] <= RSTV;
                else if (data_we && (index_q == BYTE_W'(gi)))
                    regs_o[gi] <= (regs_o[gi] & KEEP) | (wdata & ~KEEP);
            end
        end else begin : g_ro
            always_ff @(posedge clk) begin
                regs_o[gi] <= RSTV;
            end
        end
    end

    always_comb begin
        data_o = '0;
        for (int i = 0; i < NUM_REGS; i++)
            if (index_q == BYTE_W'(i)) data_o = regs_o[i];
    end

    assign index_o = index_q;

endmodule

// File: rtl/cfgshd_route.sv
module cfgshd_route
    import cfgshd_pkg::*;
#(
    parameter int ADDR_W    = 20,
    parameter int SEG_SHIFT = 14,
    parameter int NUM_SHD   = 6,
    parameter int BASE_SEG  = 40,
    parameter int BIOS_SEG  = 56
) (
    input  logic [ADDR_W-1:0]               mem_addr,
    input  logic [NUM_SHD-1:0][BYTE_W-1:0]  shd,
    output logic                            rd_internal,
    output logic                            wr_internal,
    output logic                            bios_rd,
    output logic                            bios_wr
);

    localparam int SEG_W    = ADDR_W - SEG_SHIFT;
    localparam int FIELDS   = BYTE_W / 2;

    logic [SEG_W-1:0] seg;
    seg_route_t       route;

    assign seg = mem_addr[ADDR_W-1:SEG_SHIFT];

    always_comb begin
        route   = decode_code(2'b11);
        bios_rd = 1'b0;
        bios_wr = 1'b0;
        for (int r = 0; r < NUM_SHD; r++) begin
            for (int f = 0; f < FIELDS; f++) begin
                if (seg == SEG_W'(BASE_SEG + r*FIELDS + f))
                    route = decode_code(shd[r][f*2 +: 2]);
                if ((BASE_SEG + r*FIELDS + f) >= BIOS_SEG) begin
                    bios_rd = bios_rd | decode_code(shd[r][f*2 +: 2]).rd_int;
                    bios_wr = bios_wr | decode_code(shd[r][f*2 +: 2]).wr_int;
                end
            end
        end
    end

    assign rd_internal = route.rd_int;
    assign wr_internal = route.wr_int;

endmodule

// File: rtl/cfgshd_sideport.sv
module cfgshd_sideport (
    input  logic clk,
    input  logic rst,
    input  logic a20_clr,
    input  logic a20_set,
    input  logic reset_req,
    output logic a20_gate,
    output logic soft_reset
);

    always_ff @(posedge clk) begin
        if (rst) begin
            a20_gate   <= 1'b0;
            soft_reset <= 1'b0;
        end else begin
            if (a20_clr)      a20_gate <= 1'b0;
            else if (a20_set) a20_gate <= 1'b1;
            soft_reset <= reset_req;
        end
    end

endmodule

// File: rtl/cfgshd_top.sv
module cfgshd_top
    import cfgshd_pkg::*;
#(
    parameter logic [15:0] IO_BASE   = 16'h00EC,
    parameter int          NUM_REGS  = 37,
    parameter int          WIN_LO    = 1,
    parameter int          WIN_HI    = 36,
    parameter int          LOCK_IDX  = 5,
    parameter logic [7:0]  LOCK_MASK = 8'h10,
    parameter int          SHD_FIRST = 13,
    parameter int          NUM_SHD   = 6,
    parameter int          ADDR_W    = 20,
    parameter int          SEG_SHIFT = 14,
    parameter int          UMA_BASE  = 'hA0000,
    parameter int          BIOS_BASE = 'hE0000
) (
    input  logic        clk,
    input  logic        rst,
    input  logic [15:0] io_addr,
    input  logic [7:0]  io_wdata,
    input  logic        io_wr,
    input  logic        io_rd,
    output logic [7:0]  io_rdata,
    input  logic [19:0] mem_addr,
    output logic        rd_internal,
    output logic        wr_internal,
    output logic        bios_shd_rd,
    output logic        bios_shd_wr,
    output logic        a20_gate,
    output logic        soft_reset
);

    localparam int BASE_SEG = UMA_BASE  >> SEG_SHIFT;
    localparam int BIOS_SEG = BIOS_BASE >> SEG_SHIFT;

    port_sel_t psel;
    cfg_byte_t index_q, data_q;
    logic [NUM_REGS-1:0][BYTE_W-1:0] regs;
    logic [NUM_SHD-1:0][BYTE_W-1:0]  shd;

    assign psel = port_decode(io_addr, IO_BASE);

    cfgshd_regbank #(
        .NUM_REGS (NUM_REGS),
        .WIN_LO   (WIN_LO),
        .WIN_HI   (WIN_HI),
        .LOCK_IDX (LOCK_IDX),
        .LOCK_MASK(LOCK_MASK)
    ) u_bank (
        .clk    (clk),
        .rst    (rst),
        .idx_we (io_wr && (psel == PSEL_INDEX)),
        .data_we(io_wr && (psel == PSEL_DATA)),
        .wdata  (io_wdata),
        .index_o(index_q),
        .data_o (data_q),
        .regs_o (regs)
    );

    for (genvar gs = 0; gs < NUM_SHD; gs++) begin : g_shd
        assign shd[gs] = regs[SHD_FIRST + gs];
    end

    cfgshd_route #(
        .ADDR_W   (ADDR_W),
        .SEG_SHIFT(SEG_SHIFT),
        .NUM_SHD  (NUM_SHD),
        .BASE_SEG (BASE_SEG),
        .BIOS_SEG (BIOS_SEG)
    ) u_route (
        .mem_addr   (mem_addr),
        .shd        (shd),
        .rd_internal(rd_internal),
        .wr_internal(wr_internal),
        .bios_rd    (bios_shd_rd),
        .bios_wr    (bios_shd_wr)
    );

    cfgshd_sideport u_side (
        .clk       (clk),
        .rst       (rst),
        .a20_clr   (io_wr && (psel == PSEL_A20)),
        .a20_set   (io_rd && (psel == PSEL_A20)),
        .reset_req (io_rd && (psel == PSEL_RESET)),
        .a20_gate  (a20_gate),
        .soft_reset(soft_reset)
    );

    always_comb begin
        case (psel)
            PSEL_INDEX: io_rdata = index_q;
            PSEL_DATA:  io_rdata = data_q;
            default:    io_rdata = 8'hFF;
        endcase
    end

endmodule

// File: rtl/cfgshd_chk.sv
module cfgshd_chk (
    input logic        clk,
    input logic        rst,
    input logic [15:0] io_addr,
    input logic [7:0]  io_wdata,
    input logic        io_wr,
    input logic        io_rd,
    input logic [7:0]  io_rdata,
    input logic [19:0] mem_addr,
    input logic        rd_internal,
    input logic        wr_internal,
    input logic        bios_shd_rd,
    input logic        bios_shd_wr,
    input logic        a20_gate,
    input logic        soft_reset
);

    logic hit_a20, hit_rst, hit_idx;
    assign hit_a20 = (io_addr == 16'h00EE);
    assign hit_rst = (io_addr == 16'h00EF);
    assign hit_idx = (io_addr == 16'h00EC);

    assert_index_echo_R1: assert property (@(posedge clk) disable iff (rst)
        (io_wr && hit_idx) |=> (!hit_idx || io_rdata == $past(io_wdata)));

    assert_below_uma_R7: assert property (@(posedge clk) disable iff (rst)
        (mem_addr < 20'hA0000) |-> (rd_internal && wr_internal));

    assert_bios_rd_flag_R8: assert property (@(posedge clk) disable iff (rst)
        (mem_addr >= 20'hE0000 && rd_internal) |-> bios_shd_rd);

    assert_bios_wr_flag_R8: assert property (@(posedge clk) disable iff (rst)
        (mem_addr >= 20'hE0000 && wr_internal) |-> bios_shd_wr);

    assert_a20_clear_R9: assert property (@(posedge clk) disable iff (rst)
        (io_wr && hit_a20) |=> !a20_gate);

    assert_a20_set_R9: assert property (@(posedge clk) disable iff (rst)
        (io_rd && hit_a20) |=> a20_gate);

    assert_a20_hold_R9: assert property (@(posedge clk) disable iff (rst)
        !((io_rd || io_wr) && hit_a20) |=> $stable(a20_gate));

    assert_reset_cause_R10: assert property (@(posedge clk) disable iff (rst)
        $rose(soft_reset) |-> $past(io_rd && hit_rst));

    assert_reset_pulse_R10: assert property (@(posedge clk) disable iff (rst)
        (soft_reset && !(io_rd && hit_rst)) |=> !soft_reset);

    assert_side_ports_ff_R11: assert property (@(posedge clk) disable iff (rst)
        (hit_a20 || hit_rst) |-> (io_rdata == 8'hFF));

endmodule

bind cfgshd_top cfgshd_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .io_addr    (io_addr),
    .io_wdata   (io_wdata),
    .io_wr      (io_wr),
    .io_rd      (io_rd),
    .io_rdata   (io_rdata),
    .mem_addr   (mem_addr),
    .rd_internal(rd_internal),
    .wr_internal(wr_internal),
    .bios_shd_rd(bios_shd_rd),
    .bios_shd_wr(bios_shd_wr),
    .a20_gate   (a20_gate),
    .soft_reset (soft_reset)
);

// File: tb/cfgshd_top_tb.sv
`timescale 1ns/1ps
module cfgshd_top_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] io_addr = '0;
    logic [7:0]  io_wdata = '0;
    logic        io_wr = 1'b0;
    logic        io_rd = 1'b0;
    logic [7:0]  io_rdata;
    logic [19:0] mem_addr = '0;
    logic        rd_internal, wr_internal, bios_shd_rd, bios_shd_wr;
    logic        a20_gate, soft_reset;

    int checks = 0;
    int errors = 0;
    bit done = 0;
    logic [7:0] model [0:255];

    always #2 clk = ~clk;

    cfgshd_top u_dut (
        .clk(clk), .rst(rst), .io_addr(io_addr), .io_wdata(io_wdata),
        .io_wr(io_wr), .io_rd(io_rd), .io_rdata(io_rdata), .mem_addr(mem_addr),
        .rd_internal(rd_internal), .wr_internal(wr_internal),
        .bios_shd_rd(bios_shd_rd), .bios_shd_wr(bios_shd_wr),
        .a20_gate(a20_gate), .soft_reset(soft_reset)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] rst_val(input int i);
        case (i)
            0: return 8'h90; 1: return 8'hFF; 2: return 8'h8A;
            3: return 8'h88; 6: return 8'h1B; 8: return 8'h38;
            default: return 8'h00;
        endcase
    endfunction

    function automatic logic [1:0] exp_code(input logic [19:0] a);
        int seg = int'(a >> 14);
        if (seg < 40) return 2'b11;
        return 2'((model[13 + (seg - 40) / 4] >> (2 * ((seg - 40) % 4))) & 8'h03);
    endfunction

    function automatic logic [1:0] exp_bios();
        logic [1:0] f = 2'b00;
        for (int r = 17; r <= 18; r++)
            for (int k = 0; k < 4; k++) begin
                f[1] = f[1] | model[r][2*k+1];
                f[0] = f[0] | model[r][2*k];
            end
        return f;
    endfunction

    task automatic io_write(input logic [15:0] a, input logic [7:0] d);
        io_addr = a; io_wdata = d; io_wr = 1'b1;
        @(negedge clk);
        io_wr = 1'b0;
    endtask

    task automatic io_read(input logic [15:0] a, output logic [7:0] d);
        io_addr = a; io_rd = 1'b1;
        #1 d = io_rdata;
        @(negedge clk);
        io_rd = 1'b0;
    endtask

    task automatic cfg_write(input logic [7:0] idx, input logic [7:0] d);
        io_write(16'h00EC, idx);
        io_write(16'h00ED, d);
        if (idx >= 8'h01 && idx <= 8'h24) begin
            if (idx == 8'h05) model[idx] = (model[idx] & 8'h10) | (d & 8'hEF);
            else              model[idx] = d;
        end
    endtask

    task automatic cfg_check(input logic [7:0] idx, input string tag);
        logic [7:0] d;
        io_write(16'h00EC, idx);
        io_read(16'h00EC, d);
        chk(d == idx, "R1 index readback", d, idx);
        io_read(16'h00ED, d);
        chk(d == model[idx], tag, d, model[idx]);
    endtask

    task automatic route_check(input logic [19:0] a, input string tag);
        logic [1:0] e, b;
        mem_addr = a;
        #1;
        e = exp_code(a);
        b = exp_bios();
        chk({rd_internal, wr_internal} == e, tag, {rd_internal, wr_internal}, e);
        chk({bios_shd_rd, bios_shd_wr} == b, "R8 bios flags", {bios_shd_rd, bios_shd_wr}, b);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog expired actual=0 expected=1");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [7:0] d;
        void'($urandom(32'd20240611));
        for (int i = 0; i < 256; i++) model[i] = rst_val(i);
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // reset state
        chk(a20_gate == 1'b0, "R9 a20 reset", a20_gate, 0);
        chk(soft_reset == 1'b0, "R10 reset idle", soft_reset, 0);
        io_read(16'h00EC, d);
        chk(d == 8'h00, "R1 index reset", d, 0);
        for (int i = 0; i <= 'h2A; i++) cfg_check(8'(i), "R2 reset value");
        cfg_check(8'hFF, "R2 high index reads zero");

        // R3: writes outside window ignored
        cfg_write(8'h00, 8'h55);
        cfg_check(8'h00, "R3 id write ignored");
        cfg_write(8'h25, 8'hA5);
        cfg_check(8'h25, "R3 index 0x25 write ignored");
        cfg_write(8'h24, 8'h3C);
        cfg_check(8'h24, "R3 index 0x24 writable");
        cfg_check(8'h23, "R3 neighbour untouched");

        // R4: locked bit in register 0x05
        cfg_write(8'h05, 8'hFF);
        cfg_check(8'h05, "R4 bit4 kept");
        cfg_write(8'h05, 8'h00);
        cfg_check(8'h05, "R4 clear others");

        // R5/R6 directed: fields 00,01,10,11 from low to high in region A
        cfg_write(8'h0D, 8'hE4);
        route_check(20'hA0000, "R6 lowest segment code 00");
        route_check(20'hA4000, "R5 code 01 write internal");
        route_check(20'hA8123, "R5 code 10 read internal");
        route_check(20'hAFFFF, "R6 highest segment code 11");
        cfg_write(8'h12, 8'h80);
        route_check(20'hFC000, "R6 top segment");
        route_check(20'hF0000, "R5 top region low segment external");

        // R7
        route_check(20'h00000, "R7 low memory internal");
        route_check(20'h9FFFF, "R7 just below upper area");

        // random register traffic
        for (int n = 0; n < 300; n++) begin
            logic [7:0] idx = 8'($urandom_range(0, 'h2F));
            cfg_write(idx, 8'($urandom));
            cfg_check(idx, "R3 random write readback");
            route_check(20'($urandom_range('h80000, 'hFFFFF)), "R5 random routing");
        end
        for (int n = 0; n < 40; n++) begin
            cfg_write(8'(13 + $urandom_range(0, 5)), 8'($urandom));
            route_check(20'($urandom_range('hA0000, 'hFFFFF)), "R6 random routing");
        end
        cfg_write(8'h11, 8'h00); cfg_write(8'h12, 8'h00);
        route_check(20'hE0000, "R8 flags clear");
        cfg_write(8'h12, 8'h04);
        route_check(20'hF4000, "R8 write flag only");
        cfg_write(8'h11, 8'h20);
        route_check(20'hE8000, "R8 read flag");

        // R9: A20 gate
        io_read(16'h00EE, d);
        chk(d == 8'hFF, "R11 port EE reads FF", d, 8'hFF);
        chk(a20_gate == 1'b1, "R9 read sets a20", a20_gate, 1);
        io_read(16'h00EC, d);
        chk(a20_gate == 1'b1, "R9 a20 holds", a20_gate, 1);
        io_write(16'h00EE, 8'hFF);
        chk(a20_gate == 1'b0, "R9 write clears a20", a20_gate, 0);

        // R10: soft reset pulse
        chk(soft_reset == 1'b0, "R10 idle before", soft_reset, 0);
        io_read(16'h00EF, d);
        chk(d == 8'hFF, "R11 port EF reads FF", d, 8'hFF);
        chk(soft_reset == 1'b1, "R10 pulse high", soft_reset, 1);
        @(negedge clk);
        chk(soft_reset == 1'b0, "R10 pulse one cycle", soft_reset, 0);
        io_write(16'h00EF, 8'h00);
        chk(soft_reset == 1'b0, "R10 write no pulse", soft_reset, 0);

        // R11: unhandled ports
        io_read(16'h0080, d);
        chk(d == 8'hFF, "R11 unhandled port", d, 8'hFF);
        io_read(16'h01EC, d);
        chk(d == 8'hFF, "R11 aliased port", d, 8'hFF);

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule